// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block supervises a processor with a watchdog counter. The counter advances on a free-running tick input and restarts on a kick input. When the count reaches its selected limit it either raises an interrupt, requests a system reset, or does both in sequence. In the sequenced (combined) mode the first timeout interrupts the CPU. Servicing that interrupt disarms the interrupt enable, so a later timeout resets the system unless software re-arms it.

A second byte register keeps a sticky record of which events caused a system reset: power-on, external pin, brown-out, USB bus reset and the watchdog itself. Software reads it after start-up and clears the flags it has handled. Both registers sit on a small register bus with one address bit. Clearing the reset enable or changing the timeout is guarded by a short timed unlock sequence.

Top module: `wdt_guard`

## Requirements
- R1: After `rst` the control byte reads 0x00, the cause byte reads 0x01, and `irq_req` and `sys_rst_req` are low.
- R2: The timeout is `BASE_TICKS << S` ticks after a kick, where S is the 4-bit prescaler value P = {ctrl bit5, ctrl bits 2..0} limited to 9; P values 10 to 15 behave as 9.
- R3: With ctrl bit6 (interrupt enable) set and bit3 (reset enable) clear, a timeout sets ctrl bit7 (interrupt flag). `irq_req` is a register that is high one clock after the flag and enable are both set and `gie` was high.
- R4: The interrupt flag clears on `irq_ack` or on a control write with bit7 = 1. A write with bit7 = 0 leaves it unchanged. A timeout in the same cycle as a clear leaves it set.
- R5: With reset enable set and interrupt enable clear, a timeout gives a one-cycle `sys_rst_req` pulse. The same timeout sets the watchdog cause flag and returns the control byte to 0x00.
- R6: With both enables set (combined mode), a timeout with the flag clear only sets the flag. A timeout while the flag is still set requests a system reset.
- R7: In combined mode `irq_ack` clears both the interrupt flag and the interrupt enable, so the next timeout resets the system.
- R8: `wd_kick` restarts the count from zero. A kick in the cycle of the final tick suppresses that timeout.
- R9: Reset enable can be set by any write. Clearing it or changing the prescaler takes effect only for a write made within 4 cycles after a write with bit4 (change enable) and bit3 both 1. Bit4 reads 1 while this window is open. The window closes after one such write or after 4 cycles.
- R10: Cause byte layout: bit5 USB, bit3 watchdog, bit2 brown-out, bit1 external, bit0 power-on; bit4, bit6 and bit7 read 0. Each `ev_*` pulse sets its flag, returns the control byte to 0x00 and restarts the count.
- R11: A cause write clears each flag whose data bit is 0 and leaves flags written with 1 unchanged. An event in the same cycle as a clear leaves its flag set.
- R12: `rst` clears every cause flag except the power-on flag, which it sets. The power-on flag is cleared only by a software write of 0.
- R13: `bus_addr` 0 selects the control byte and 1 selects the cause byte. `bus_rdata` is registered and shows the selected byte as it stood before the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| bus_addr | input | 1 | Register select: 0 control, 1 cause |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wd_tick | input | 1 | Watchdog count tick |
| wd_kick | input | 1 | Restart the watchdog count |
| gie | input | 1 | CPU global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge (vector taken) |
| ev_ext | input | 1 | External reset event pulse |
| ev_bor | input | 1 | Brown-out reset event pulse |
| ev_usb | input | 1 | USB bus reset event pulse |
| irq_req | output | 1 | Interrupt request |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A timeout can fall in the same cycle as a clear of the interrupt flag by acknowledge. A cause event can also coincide with a software clear of the same flag. The bench anchors the counter with a kick so that the timeout edge is known, then places the acknowledge exactly on that edge. It expects the flag and `irq_req` to stay set, and expects a later lone acknowledge to drop them. The same approach places a kick on the final tick and expects no reset. It also drives an external event together with a cause write of zero and expects the external flag to read back as 1.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  // control byte bit positions (software decodes these)
  localparam int CTL_IF = 7;
  localparam int CTL_IE = 6;
  localparam int CTL_P3 = 5;
  localparam int CTL_CE = 4;
  localparam int CTL_RE = 3;
  localparam int PS_W   = 4;

  // cause byte bit positions
  localparam int CS_USB = 5;
  localparam int CS_WD  = 3;
  localparam int CS_BOR = 2;
  localparam int CS_EXT = 1;
  localparam int CS_POR = 0;

  localparam logic [7:0] CS_LIVE = 8'((1 << CS_USB) | (1 << CS_WD) | (1 << CS_BOR) |
                                      (1 << CS_EXT) | (1 << CS_POR));
  localparam logic [7:0] CS_PON  = 8'(1 << CS_POR);

  // operating mode, encoded as {reset enable, interrupt enable}
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_IRQ  = 2'b01,
    MODE_RST  = 2'b10,
    MODE_BOTH = 2'b11
  } wd_mode_e;
endpackage

// File: rtl/wdt_guard_timer.sv
module wdt_guard_timer
  import wdt_guard_pkg::*;
#(
  parameter int BASE_TICKS = 2048,
  parameter int MAX_SHIFT  = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tick,
  input  logic            clr,
  input  logic [PS_W-1:0] ps,
  output logic            tout
);
  localparam int CNT_W = $clog2(BASE_TICKS) + MAX_SHIFT + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [PS_W-1:0]  shamt;

  always_comb begin
    shamt = (ps > PS_W'(MAX_SHIFT)) ? PS_W'(MAX_SHIFT) : ps;
    lim   = CNT_W'(BASE_TICKS) << shamt;
  end

  // a restart in the same cycle as the last tick wins
  assign tout = run && tick && !clr && (cnt_q >= lim - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= tout ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_guard_ctrl.sv
module wdt_guard_ctrl
  import wdt_guard_pkg::*;
#(
  parameter int WIN_CYC = 4,
  parameter bit RE_INIT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            warm,
  input  logic            wr_en,
  input  logic [7:0]      wdata,
  input  logic            irq_ack,
  input  logic            gie,
  input  logic            tout,
  output logic [7:0]      ctl_byte,
  output logic [PS_W-1:0] ps,
  output logic            run,
  output logic            fire,
  output logic            win_open,
  output logic            re_out,
  output logic            irq_req,
  output logic            sys_rst_req
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic            if_q, ie_q, re_q, irq_q, srst_q;
  logic [PS_W-1:0] ps_q;
  logic [WIN_W-1:0] win_q;
  logic            if_n, ie_n, re_n;
  logic [PS_W-1:0] ps_n;
  logic [WIN_W-1:0] win_n;
  wd_mode_e        mode;
  logic            set_if, prot, open_w, clr_all;

  // timeout outcome per mode
  always_comb begin
    mode   = wd_mode_e'({re_q, ie_q});
    fire   = 1'b0;
    set_if = 1'b0;
    if (tout) begin
      case (mode)
        MODE_IRQ:  set_if = 1'b1;
        MODE_RST:  fire   = 1'b1;
        MODE_BOTH: begin
          if (if_q) fire = 1'b1;
          else      set_if = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign win_open = (win_q != '0);
  assign prot     = wr_en && win_open;
  assign open_w   = wr_en && !win_open && wdata[CTL_CE] && wdata[CTL_RE];
  assign clr_all  = rst || warm || fire;

  always_comb begin
    if_n = if_q;
    if (irq_ack || (wr_en && wdata[CTL_IF])) if_n = 1'b0;
    if (set_if) if_n = 1'b1;

    ie_n = ie_q;
    if (wr_en) ie_n = wdata[CTL_IE];
    if (irq_ack && re_q) ie_n = 1'b0;

    re_n = re_q;
    ps_n = ps_q;
    if (prot) begin
      re_n = wdata[CTL_RE];
      ps_n = {wdata[CTL_P3], wdata[2:0]};
    end else if (wr_en && wdata[CTL_RE]) begin
      re_n = 1'b1;
    end

    if (open_w)                win_n = WIN_W'(WIN_CYC);
    else if (prot || !win_open) win_n = '0;
    else                       win_n = win_q - WIN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (clr_all) begin
      if_q  <= 1'b0;
      ie_q  <= 1'b0;
      re_q  <= RE_INIT;
      ps_q  <= '0;
      win_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if_q  <= if_n;
      ie_q  <= ie_n;
      re_q  <= re_n;
      ps_q  <= ps_n;
      win_q <= win_n;
      irq_q <= if_n && ie_n && gie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= fire;
  end

  assign ctl_byte    = {if_q, ie_q, ps_q[3], win_open, re_q, ps_q[2:0]};
  assign ps          = ps_q;
  assign run         = ie_q || re_q;
  assign re_out      = re_q;
  assign irq_req     = irq_q;
  assign sys_rst_req = srst_q;
endmodule

// File: rtl/wdt_guard_cause.sv
module wdt_guard_cause
  import wdt_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       ev_usb,
  input  logic       ev_wd,
  input  logic       ev_bor,
  input  logic       ev_ext,
  output logic [7:0] flags
);
  logic [7:0] cq, set_v, clr_v;

  always_comb begin
    set_v         = '0;
    set_v[CS_USB] = ev_usb;
    set_v[CS_WD]  = ev_wd;
    set_v[CS_BOR] = ev_bor;
    set_v[CS_EXT] = ev_ext;
    clr_v         = wr_en ? ~wdata : '0;
  end

  // an event beats a software clear of the same flag
  always_ff @(posedge clk) begin
    if (rst) cq <= CS_PON;
    else     cq <= ((cq & ~clr_v) | set_v) & CS_LIVE;
  end

  assign flags = cq;
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int BASE_TICKS = 2048,
  parameter int MAX_SHIFT  = 9,
  parameter int WIN_CYC    = 4,
  parameter bit RE_INIT    = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       wd_tick,
  input  logic       wd_kick,
  input  logic       gie,
  input  logic       irq_ack,
  input  logic       ev_ext,
  input  logic       ev_bor,
  input  logic       ev_usb,
  output logic       irq_req,
  output logic       sys_rst_req
);
  logic            ev_any, tout_w, fire_w, run_w, win_w, re_w;
  logic            wr_ctl, wr_cs;
  logic [PS_W-1:0] ps_w;
  logic [7:0]      ctl_byte, cause_byte, rd_q;

  assign ev_any = ev_ext || ev_bor || ev_usb;
  assign wr_ctl = bus_wr && !bus_addr;
  assign wr_cs  = bus_wr && bus_addr;

  wdt_guard_timer #(
    .BASE_TICKS(BASE_TICKS),
    .MAX_SHIFT (MAX_SHIFT)
  ) u_timer (
    .clk (clk),
    .rst (rst),
    .run (run_w),
    .tick(wd_tick),
    .clr (wd_kick || ev_any),
    .ps  (ps_w),
    .tout(tout_w)
  );

  wdt_guard_ctrl #(
    .WIN_CYC(WIN_CYC),
    .RE_INIT(RE_INIT)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .warm       (ev_any),
    .wr_en      (wr_ctl),
    .wdata      (bus_wdata),
    .irq_ack    (irq_ack),
    .gie        (gie),
    .tout       (tout_w),
    .ctl_byte   (ctl_byte),
    .ps         (ps_w),
    .run        (run_w),
    .fire       (fire_w),
    .win_open   (win_w),
    .re_out     (re_w),
    .irq_req    (irq_req),
    .sys_rst_req(sys_rst_req)
  );

  wdt_guard_cause u_cause (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_cs),
    .wdata (bus_wdata),
    .ev_usb(ev_usb),
    .ev_wd (fire_w),
    .ev_bor(ev_bor),
    .ev_ext(ev_ext),
    .flags (cause_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= bus_addr ? cause_byte : ctl_byte;
  end

  assign bus_rdata = rd_q;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       sys_rst_req,
  input logic       irq_req,
  input logic       gie,
  input logic       irq_ack,
  input logic       tout,
  input logic       fire,
  input logic       iflag,
  input logic       re_q,
  input logic       win_open,
  input logic       warm,
  input logic [7:0] cause
);
  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> !sys_rst_req); // R5
  AST_RST_SETS_WD: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> cause[3]); // R5
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(gie)); // R3
  AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !tout) |=> !iflag); // R4
  AST_RE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (re_q && !win_open && !warm && !fire) |=> re_q); // R9
  AST_POR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cause == 8'h01)); // R12
endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sys_rst_req(sys_rst_req),
  .irq_req    (irq_req),
  .gie        (gie),
  .irq_ack    (irq_ack),
  .tout       (tout_w),
  .fire       (fire_w),
  .iflag      (ctl_byte[7]),
  .re_q       (re_w),
  .win_open   (win_w),
  .warm       (ev_any),
  .cause      (cause_byte)
);

// File: tb/wdt_guard_bench.sv
`timescale 1ns/1ps
module wdt_guard_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       wd_tick = 1'b0;
  logic       wd_kick = 1'b0;
  logic       gie = 1'b1;
  logic       irq_ack = 1'b0;
  logic       ev_ext = 1'b0;
  logic       ev_bor = 1'b0;
  logic       ev_usb = 1'b0;
  logic       irq_req;
  logic       sys_rst_req;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdt_guard #(.BASE_TICKS(4)) u_wdt_guard (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_tick(wd_tick),
    .wd_kick(wd_kick), .gie(gie), .irq_ack(irq_ack), .ev_ext(ev_ext),
    .ev_bor(ev_bor), .ev_usb(ev_usb), .irq_req(irq_req),
    .sys_rst_req(sys_rst_req)
  );

  // {requirement number, write data, expected control readback}
  localparam logic [23:0] TBL [0:8] = '{
    {8'd13, 8'h40, 8'h40},
    {8'd4,  8'h80, 8'h00},
    {8'd9,  8'h08, 8'h08},
    {8'd9,  8'h00, 8'h08},
    {8'd9,  8'h27, 8'h08},
    {8'd13, 8'h48, 8'h48},
    {8'd9,  8'h18, 8'h18},
    {8'd9,  8'h25, 8'h25},
    {8'd9,  8'h08, 8'h2D}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    steps(2);
    rst = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic wr_cause(input logic [7:0] d);
    bus_addr = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic kick();
    wd_kick = 1'b1;
    step();
    wd_kick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    bit seen;
    steps(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq_req", {7'd0, irq_req}, 8'h00);
    chk("R1 sys_rst_req", {7'd0, sys_rst_req}, 8'h00);
    step();
    chk("R1 ctrl", bus_rdata, 8'h00);
    bus_addr = 1'b1;
    step();
    chk("R1 cause", bus_rdata, 8'h01);

    // control write/readback table, count halted (R9, R13, R4)
    for (int i = 0; i < 9; i++) begin
      wr_ctrl(TBL[i][15:8]);
      step();
      chk($sformatf("R%0d table[%0d]", TBL[i][23:16], i), bus_rdata, TBL[i][7:0]);
    end

    // R9 window expiry and last-cycle boundary
    do_reset();
    wr_ctrl(8'h08);
    wr_ctrl(8'h18);
    step();
    chk("R9 change enable reads 1", bus_rdata, 8'h18);
    steps(3);
    wr_ctrl(8'h00);
    step();
    chk("R9 late write rejected", bus_rdata, 8'h08);
    wr_ctrl(8'h18);
    steps(3);
    wr_ctrl(8'h00);
    step();
    chk("R9 fourth-cycle write accepted", bus_rdata, 8'h00);

    // R3 / R4 interrupt mode
    do_reset();
    wd_tick = 1'b1;
    gie = 1'b1;
    wr_ctrl(8'h40);
    kick();
    steps(3);
    chk("R2 no irq before limit", {7'd0, irq_req}, 8'h00);
    step();
    chk("R3 irq at timeout", {7'd0, irq_req}, 8'h01);
    steps(3);
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    chk("R4 timeout beats ack", {7'd0, irq_req}, 8'h01);
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    chk("R4 ack clears", {7'd0, irq_req}, 8'h00);
    step();
    chk("R4 ctrl after ack", bus_rdata, 8'h40);
    gie = 1'b0;
    steps(2);
    chk("R3 gie low blocks irq", {7'd0, irq_req}, 8'h00);
    step();
    chk("R3 flag set with gie low", bus_rdata, 8'hC0);
    wr_ctrl(8'h80);
    step();
    chk("R4 write one clears flag", bus_rdata, 8'h00);
    gie = 1'b1;

    // R5 reset mode
    wr_ctrl(8'h08);
    kick();
    steps(3);
    chk("R5 no reset before limit", {7'd0, sys_rst_req}, 8'h00);
    step();
    chk("R5 reset at timeout", {7'd0, sys_rst_req}, 8'h01);
    step();
    chk("R5 reset is one cycle", {7'd0, sys_rst_req}, 8'h00);
    chk("R5 ctrl cleared", bus_rdata, 8'h00);
    bus_addr = 1'b1;
    step();
    chk("R10 watchdog flag", bus_rdata, 8'h09);

    // R8 kick keeps it quiet; kick on the last tick
    wr_ctrl(8'h08);
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      kick();
      if (sys_rst_req) seen = 1'b1;
      step();
      if (sys_rst_req) seen = 1'b1;
      step();
      if (sys_rst_req) seen = 1'b1;
    end
    chk("R8 regular kicks", {7'd0, seen}, 8'h00);
    kick();
    steps(3);
    kick();
    chk("R8 kick on final tick", {7'd0, sys_rst_req}, 8'h00);
    steps(3);
    step();
    chk("R8 restarted count expires", {7'd0, sys_rst_req}, 8'h01);

    // R6 combined mode, no service
    wr_ctrl(8'h48);
    kick();
    steps(4);
    chk("R6 first timeout irq", {7'd0, irq_req}, 8'h01);
    chk("R6 first timeout no reset", {7'd0, sys_rst_req}, 8'h00);
    steps(4);
    chk("R6 second timeout resets", {7'd0, sys_rst_req}, 8'h01);

    // R7 combined mode with service
    bus_addr = 1'b0;
    wr_ctrl(8'h48);
    kick();
    steps(4);
    chk("R7 irq raised", {7'd0, irq_req}, 8'h01);
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    chk("R7 irq dropped", {7'd0, irq_req}, 8'h00);
    step();
    chk("R7 enable cleared", bus_rdata, 8'h08);
    step();
    step();
    chk("R7 next timeout resets", {7'd0, sys_rst_req}, 8'h01);

    // R2 prescaler 9 and saturated 15
    wr_ctrl(8'h18);
    wr_ctrl(8'h29);
    kick();
    steps(2047);
    chk("R2 ps9 before limit", {7'd0, sys_rst_req}, 8'h00);
    step();
    chk("R2 ps9 at limit", {7'd0, sys_rst_req}, 8'h01);
    wr_ctrl(8'h18);
    wr_ctrl(8'h2F);
    kick();
    steps(2047);
    chk("R2 ps15 before limit", {7'd0, sys_rst_req}, 8'h00);
    step();
    chk("R2 ps15 saturates", {7'd0, sys_rst_req}, 8'h01);

    // R10 R11 R12 cause register
    wd_tick = 1'b0;
    do_reset();
    bus_addr = 1'b1;
    step();
    chk("R12 power-on only", bus_rdata, 8'h01);
    wr_ctrl(8'h40);
    ev_ext = 1'b1;
    step();
    ev_ext = 1'b0;
    step();
    chk("R10 event clears ctrl", bus_rdata, 8'h00);
    bus_addr = 1'b1;
    step();
    chk("R10 external flag", bus_rdata, 8'h03);
    ev_bor = 1'b1;
    step();
    ev_bor = 1'b0;
    step();
    chk("R10 brown-out flag", bus_rdata, 8'h07);
    ev_usb = 1'b1;
    step();
    ev_usb = 1'b0;
    step();
    chk("R10 usb flag", bus_rdata, 8'h27);
    wr_cause(8'hFF);
    step();
    chk("R11 write ones no effect", bus_rdata, 8'h27);
    wr_cause(8'h25);
    step();
    chk("R11 write zero clears", bus_rdata, 8'h25);
    bus_wr = 1'b1;
    bus_wdata = 8'h00;
    ev_ext = 1'b1;
    step();
    bus_wr = 1'b0;
    ev_ext = 1'b0;
    step();
    chk("R11 event beats clear", bus_rdata, 8'h02);
    do_reset();
    step();
    chk("R12 reset sets power-on", bus_rdata, 8'h01);
    wr_cause(8'h00);
    step();
    chk("R12 power-on cleared by write", bus_rdata, 8'h00);
    ev_ext = 1'b1;
    step();
    ev_ext = 1'b0;
    do_reset();
    step();
    chk("R12 reset clears others", bus_rdata, 8'h01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule